// File: doc/BRIEF.md
# Command Queue Slot Address Generator

This block turns a free-running 64-bit queue index into the byte address of a 64-byte packet slot inside a ring held in host memory. Software sets the ring up once by loading a base address, an element count and a mode flag. After that, every lookup index presented on a valid/ready input stream produces one slot address on a valid/ready output stream, one cycle later. The block performs no memory access itself.

The same configuration also drives a purely combinational occupancy report. From a write index and a read index supplied by the queue owner, the block reports how many slots are in use and how many are free, plus full and empty flags. In half-ring mode the index wraps at half of the declared element count. This covers queues that are allocated at twice the size of the region actually used. The element count must be a power of two, and a count that breaks this rule is flagged.

Back-pressure rules: an index is taken on any rising edge where `lkp_valid` and `lkp_ready` are both high. `lkp_ready` is low only while a result is waiting and `addr_ready` is low. A waiting result holds `addr_valid` and `addr` unchanged until it is taken.

Top module: `cq_slot_addr_gen`

## Requirements
- R1: A high `cfg_load` on a rising edge captures `cfg_base`, `cfg_elts` and `cfg_half` into the configuration, and lookups accepted on any later edge use the new values.
- R2: With `cfg_half` = 0, the address of index i is base + (i mod elts) × 64.
- R3: With `cfg_half` = 1, the address of index i is base + (i mod (elts/2)) × 64.
- R4: `used` equals wr_idx − rd_idx, taken modulo 2^64.
- R5: `free_slots` equals elts − (wr_idx − rd_idx), taken modulo 2^64.
- R6: `full` is 1 exactly when `free_slots` is 0, and `empty` is 1 exactly when `free_slots` equals elts.
- R7: `cfg_err` becomes 1 after a load whose count is zero, is not a power of two, or is 1 with `cfg_half` = 1. While `cfg_err` is 1, every lookup returns the base address.
- R8: An index accepted on a rising edge gives `addr_valid` = 1 with its address right after that edge.
- R9: While `addr_valid` = 1 and `addr_ready` = 0, `lkp_ready` is 0, and `addr` and `addr_valid` hold their values. Once `addr_ready` rises, a pending index is accepted on that same edge.
- R10: After reset, `addr_valid` is 0, `cfg_err` is 0, and the configuration is base 0 and count 0, so `free_slots` is 0 when the indices are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_base | input | 64 | Ring base byte address |
| cfg_elts | input | 32 | Declared element count |
| cfg_half | input | 1 | 1 = wrap at half the count |
| cfg_err | output | 1 | Loaded configuration is invalid |
| lkp_valid | input | 1 | Lookup index valid |
| lkp_ready | output | 1 | Lookup index accepted when high |
| lkp_idx | input | 64 | Queue index to translate |
| addr_valid | output | 1 | Slot address valid |
| addr_ready | input | 1 | Downstream takes the address |
| addr | output | 64 | Slot byte address |
| wr_idx | input | 64 | Write index |
| rd_idx | input | 64 | Read index |
| used | output | 64 | Slots in use |
| free_slots | output | 64 | Slots free |
| full | output | 1 | No slot free |
| empty | output | 1 | No slot used |

## Verification
The lookup path is swept over every index from 0 to 69, and over indices close to 2^64, for each power-of-two count from 1 to 16 in both modes. The indices past the count show that the wrap point is the full count in one mode and half the count in the other. The indices close to 2^64 show that the modulo is taken on the low bits rather than on a truncated sum. Occupancy is swept over every write/read offset from 0 to 8 on an 8-entry ring, with the read index placed both at zero and just below the 2^64 wrap, which tells correct modular subtraction apart from signed or truncated arithmetic. Separate patterns check invalid counts, a reconfiguration applied between two lookups, and a stalled output that must hold its address while a new index waits.

// File: rtl/cq_slot_pkg.sv
package cq_slot_pkg;
  localparam int unsigned SLOT_BYTES_LOG2 = 6;

  typedef enum logic {
    WRAP_FULL = 1'b0,
    WRAP_HALF = 1'b1
  } wrap_mode_e;

  function automatic logic cnt_is_pow2(input logic [31:0] n);
    return (n != 32'd0) && ((n & (n - 32'd1)) == 32'd0);
  endfunction
endpackage

// File: rtl/cq_cfg_regs.sv
module cq_cfg_regs
  import cq_slot_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [CNT_W-1:0]  elts_in,
  input  logic              half_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  elts_q,
  output logic [IDX_W-1:0]  mask_q,
  output logic              err_q
);
  wrap_mode_e       mode;
  logic             bad;
  logic [IDX_W-1:0] mask_n;

  assign mode = wrap_mode_e'(half_in);

  // Count check is done once here so the lookup path only masks.
  always_comb begin
    bad = !cnt_is_pow2(32'(elts_in)) ||
          ((mode == WRAP_HALF) && (elts_in == CNT_W'(1)));
    if (bad)
      mask_n = '0;
    else if (mode == WRAP_HALF)
      mask_n = IDX_W'(elts_in >> 1) - IDX_W'(1);
    else
      mask_n = IDX_W'(elts_in) - IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      elts_q <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      base_q <= base_in;
      elts_q <= elts_in;
      mask_q <= mask_n;
      err_q  <= bad;
    end
  end
endmodule

// File: rtl/cq_slot_addr.sv
module cq_slot_addr
  import cq_slot_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] offset;

  assign in_ready = !out_valid || out_ready;
  assign offset   = ADDR_W'(in_idx & mask) << SLOT_BYTES_LOG2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_addr  <= base + offset;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cq_occupancy.sv
module cq_occupancy #(
  parameter int unsigned IDX_W = 64,
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] elts,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] used,
  output logic [IDX_W-1:0] free_slots,
  output logic             full,
  output logic             empty
);
  logic [IDX_W-1:0] elts_w;

  assign elts_w     = IDX_W'(elts);
  assign used       = wr_idx - rd_idx;
  assign free_slots = elts_w - used;
  assign full       = (free_slots == '0);
  assign empty      = (free_slots == elts_w);
endmodule

// File: rtl/cq_slot_addr_gen.sv
module cq_slot_addr_gen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_elts,
  input  logic              cfg_half,
  output logic              cfg_err,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [IDX_W-1:0]  lkp_idx,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  used,
  output logic [IDX_W-1:0]  free_slots,
  output logic              full,
  output logic              empty
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  elts_q;
  logic [IDX_W-1:0]  mask_q;

  cq_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .base_in(cfg_base), .elts_in(cfg_elts), .half_in(cfg_half),
    .base_q(base_q), .elts_q(elts_q), .mask_q(mask_q), .err_q(cfg_err)
  );

  cq_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .base(base_q), .mask(mask_q),
    .in_valid(lkp_valid), .in_ready(lkp_ready), .in_idx(lkp_idx),
    .out_valid(addr_valid), .out_ready(addr_ready), .out_addr(addr)
  );

  cq_occupancy #(.IDX_W(IDX_W), .CNT_W(CNT_W)) occ_i (
    .elts(elts_q), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .used(used), .free_slots(free_slots), .full(full), .empty(empty)
  );
endmodule

// File: rtl/cq_slot_addr_gen_chk.sv
module cq_slot_addr_gen_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_valid,
  input logic              lkp_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] base_q,
  input logic [CNT_W-1:0]  elts_q,
  input logic              cfg_err,
  input logic [IDX_W-1:0]  used,
  input logic              full,
  input logic              empty
);
  logic [ADDR_W-1:0] rel;
  assign rel = addr - base_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr));

  // R8
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && lkp_ready |=> addr_valid);

  // R6
  empty_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !full |-> used == '0);

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !cfg_err && elts_q != '0 |->
      rel[5:0] == 6'd0 && (rel >> 6) < ADDR_W'(elts_q));
endmodule

bind cq_slot_addr_gen cq_slot_addr_gen_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
  .base_q(base_q), .elts_q(elts_q), .cfg_err(cfg_err),
  .used(used), .full(full), .empty(empty)
);

// File: tb/cq_slot_addr_gen_tb_top.sv
module cq_slot_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [63:0] cfg_base = '0;
  logic [31:0] cfg_elts = '0;
  logic        cfg_half = 1'b0;
  logic        cfg_err;
  logic        lkp_valid = 1'b0;
  logic        lkp_ready;
  logic [63:0] lkp_idx = '0;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [63:0] addr;
  logic [63:0] wr_idx = '0;
  logic [63:0] rd_idx = '0;
  logic [63:0] used, free_slots;
  logic        full, empty;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [63:0] cur_base;
  logic [31:0] cur_elts;
  logic        cur_half;

  always #5 clk = ~clk;

  cq_slot_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_elts(cfg_elts), .cfg_half(cfg_half), .cfg_err(cfg_err),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_idx(lkp_idx),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .used(used), .free_slots(free_slots),
    .full(full), .empty(empty)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [63:0] b, input logic [31:0] e, input logic h);
    @(negedge clk);
    cfg_load = 1'b1; cfg_base = b; cfg_elts = e; cfg_half = h;
    @(negedge clk);
    cfg_load = 1'b0;
    cur_base = b; cur_elts = e; cur_half = h;
  endtask

  function automatic logic [63:0] exp_addr(input logic [63:0] idx);
    logic [63:0] div;
    div = cur_half ? 64'(cur_elts / 2) : 64'(cur_elts);
    return cur_base + (idx % div) * 64;
  endfunction

  task automatic lookup(input logic [63:0] idx, input logic [63:0] exp, input string req);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_idx = idx;
    @(negedge clk);
    lkp_valid = 1'b0;
    check("R8 valid", 64'(addr_valid), 64'd1);
    check(req, addr, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 addr_valid", 64'(addr_valid), 64'd0);
    check("R10 cfg_err", 64'(cfg_err), 64'd0);
    check("R10 free_slots", free_slots, 64'd0);
    check("R10 lkp_ready", 64'(lkp_ready), 64'd1);

    // R2 / R3 sweeps over power-of-two counts, both modes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 5; k++) begin
        if (m == 1 && k == 0) continue;
        configure(64'h0000_1000_0000_0040 + 64'(k) * 64'h1_0000, 32'd1 << k, m[0]);
        check("R7 valid cfg", 64'(cfg_err), 64'd0);
        for (int i = 0; i < 70; i++)
          lookup(64'(i), exp_addr(64'(i)), m ? "R3 half wrap" : "R2 full wrap");
        for (int i = 0; i < 4; i++)
          lookup(64'hFFFF_FFFF_FFFF_FFFC + 64'(i), exp_addr(64'hFFFF_FFFF_FFFF_FFFC + 64'(i)),
                 m ? "R3 high index" : "R2 high index");
      end
    end

    // R1 reconfiguration applies to the next lookup
    configure(64'h2000, 32'd8, 1'b0);
    lookup(64'd13, 64'h2000 + 64'd5 * 64, "R1 first cfg");
    configure(64'h9000, 32'd4, 1'b1);
    lookup(64'd13, 64'h9000 + 64'd1 * 64, "R1 second cfg");

    // R7 invalid counts
    configure(64'h5000, 32'd6, 1'b0);
    check("R7 err non-pow2", 64'(cfg_err), 64'd1);
    lookup(64'd7, 64'h5000, "R7 base on error");
    configure(64'h5000, 32'd0, 1'b0);
    check("R7 err zero", 64'(cfg_err), 64'd1);
    configure(64'h5000, 32'd1, 1'b1);
    check("R7 err half of one", 64'(cfg_err), 64'd1);
    lookup(64'd3, 64'h5000, "R7 base on error half");
    configure(64'h5000, 32'd1, 1'b0);
    check("R7 err cleared", 64'(cfg_err), 64'd0);

    // R9 back-pressure
    configure(64'h4000, 32'd16, 1'b0);
    @(negedge clk);
    addr_ready = 1'b0; lkp_valid = 1'b1; lkp_idx = 64'd3;
    @(negedge clk);
    lkp_idx = 64'd21;
    for (int c = 0; c < 3; c++) begin
      check("R9 held valid", 64'(addr_valid), 64'd1);
      check("R9 held addr", addr, 64'h4000 + 64'd3 * 64);
      check("R9 ready low", 64'(lkp_ready), 64'd0);
      @(negedge clk);
    end
    addr_ready = 1'b1;
    @(negedge clk);
    lkp_valid = 1'b0;
    check("R9 pending taken", addr, 64'h4000 + 64'd5 * 64);
    @(negedge clk);
    check("R9 drained", 64'(addr_valid), 64'd0);

    // R4 / R5 / R6 occupancy sweep
    configure(64'h0, 32'd8, 1'b0);
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d <= 8; d++) begin
        logic [63:0] rb, u, f;
        rb = r ? 64'hFFFF_FFFF_FFFF_FFFD : 64'd0;
        rd_idx = rb; wr_idx = rb + 64'(d);
        u = 64'(d); f = 64'd8 - u;
        #1;
        check("R4 used", used, u);
        check("R5 free", free_slots, f);
        check("R6 full", 64'(full), 64'(f == 0));
        check("R6 empty", 64'(empty), 64'(f == 64'd8));
      end
    end
    // R5 overfilled wraps modulo 2^64
    rd_idx = 64'd0; wr_idx = 64'd10; #1;
    check("R5 overfill", free_slots, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R6 overfill not full", 64'(full), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule